// File: doc/BRIEF.md
# DC-Only Dequantize and Reconstruct Unit

This unit rebuilds one square block of 8-bit pixels when the DC term is the only nonzero residual coefficient. It does not run an inverse transform. It dequantizes the DC coefficient once and rounds it to a single signed residual. It then adds that residual to every predicted pixel of the block and clips each sum to the 8-bit range. Two block sizes are supported: a small block of 4 rows by 4 pixels and a large block of 8 rows by 8 pixels.

A job starts with a one-cycle start pulse. The pulse latches the coefficient, the inverse-scale and weight values, the left-shift amount, the block size and a pre-dequantized flag. In small-block mode this flag replaces the dequantization result with an alternate DC value that is already dequantized. A three-stage pipeline produces the residual. After that, prediction rows flow in and reconstructed rows flow out, one row per handshake beat. The unit pulses done after the last row.

Top module: `dcr_unit`

## Requirements
- R1: The scale factor is the low 16 bits of the unsigned product `iscale_i * weight_i`, read as a signed two's-complement 16-bit value.
- R2: The signed coefficient `dc_coef_i` is multiplied by the scale factor into a signed 32-bit product. That product is shifted left by `qp_shift_i` (0 to 15), and bits shifted out past bit 31 are lost.
- R3: In small-block mode (`blk8_i` = 0), the shifted product gets 8 added and is then shifted right arithmetically by 4. The result is saturated to the range -32768 to 32767 and becomes the dequantized DC value.
- R4: In large-block mode (`blk8_i` = 1), the shifted product gets 32 added and is then shifted right arithmetically by 6, with the same saturation.
- R5: The residual is the dequantized DC value plus 32, shifted right arithmetically by 6. One value is used for every row of a block.
- R6: When `pre_dq_i` = 1 in small-block mode, `dc_alt_i` is used as the dequantized DC value. In large-block mode `pre_dq_i` has no effect.
- R7: Output pixel k sits in bits [8k+7:8k]. Its value is the zero-extended predicted pixel plus the residual, clipped to 0..255. In small-block mode only pixels 0 to 3 are reconstructed: bits above 31 of `rec_row_o` are zero whatever `pred_row_i` holds there.
- R8: A start pulse is taken only while `busy_o` is low, and it latches all job inputs. A start pulse while busy, and any change of the job inputs after the pulse, leave the running block unchanged.
- R9: In the three cycles after the start edge, `pred_ready_o` and `rec_valid_o` stay low. Rows are accepted from the fourth cycle on.
- R10: While rows are being taken, `rec_valid_o` follows `pred_valid_i` and `pred_ready_o` follows `rec_ready_i`. A row moves when both valid and ready are high. While idle, both outputs are low.
- R11: A block takes exactly 4 rows in small-block mode and 8 rows in large-block mode. `done_o` is high for exactly one cycle, the cycle after the last row transfer, and `busy_o` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse, latches the job inputs |
| blk8_i | input | 1 | Block size: 0 = 4x4, 1 = 8x8 |
| pre_dq_i | input | 1 | Use `dc_alt_i` directly (4x4 only) |
| dc_coef_i | input | 16 | Signed quantized DC coefficient |
| iscale_i | input | 16 | Inverse-scale value |
| weight_i | input | 16 | Weight value |
| qp_shift_i | input | 4 | Left-shift amount (QP divided by 6) |
| dc_alt_i | input | 16 | Signed, already dequantized DC value |
| busy_o | output | 1 | A job is in progress |
| pred_valid_i | input | 1 | Prediction row valid |
| pred_ready_o | output | 1 | Prediction row accepted |
| pred_row_i | input | 64 | Prediction row, pixel k in bits [8k+7:8k] |
| rec_valid_o | output | 1 | Reconstructed row valid |
| rec_ready_i | input | 1 | Downstream accepts the reconstructed row |
| rec_row_o | output | 64 | Reconstructed row, same packing as the prediction row |
| done_o | output | 1 | One-cycle pulse after the last row |

## Verification
The bench builds the unit with its default parameters: 8-bit pixels and rows of up to 8 pixels. With these values both block sizes and the full 16-bit coefficient datapath are in reach. That covers positive and negative saturation of the dequantized value, loss of bits on the left shift at an amount of 15, and scale factors whose low half reads as negative. Residuals of ±512 push every pixel to the clip limits. Random stalls on both sides of the row handshake exercise the pass-through flow control.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  // Coefficient and shift-amount widths of the dequantizer
  localparam int COEF_W    = 16;
  localparam int QP_W      = 4;
  // Rounding right shifts for the two block sizes and for the residual
  localparam int SH_SMALL  = 4;
  localparam int SH_LARGE  = 6;
  localparam int SH_RES    = 6;
  // Residual width: a 16-bit value shifted by 6, plus one bit for rounding up
  localparam int RES_W     = COEF_W - SH_RES + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_SHF,
    ST_RES,
    ST_ROWS
  } dcr_state_e;

  typedef struct packed {
    logic              blk8;
    logic              pre_dq;
    logic [COEF_W-1:0] dc;
    logic [COEF_W-1:0] iscale;
    logic [COEF_W-1:0] weight;
    logic [QP_W-1:0]   qp;
    logic [COEF_W-1:0] alt;
  } dcr_job_t;

endpackage

// File: rtl/dcr_ctrl.sv
module dcr_ctrl
  import dcr_pkg::*;
#(
  parameter int MAX_N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic blk8_i,        // latched block size
  input  logic pred_valid_i,
  input  logic rec_ready_i,
  output logic load_job_o,
  output logic en_mul_o,
  output logic en_shf_o,
  output logic en_res_o,
  output logic pred_ready_o,
  output logic rec_valid_o,
  output logic busy_o,
  output logic done_o
);

  localparam int CNT_W = $clog2(MAX_N);
  localparam logic [CNT_W-1:0] LAST_LARGE = CNT_W'(MAX_N - 1);
  localparam logic [CNT_W-1:0] LAST_SMALL = CNT_W'(MAX_N / 2 - 1);

  dcr_state_e       state_q, state_d;
  logic [CNT_W-1:0] row_q, row_d;
  logic             done_q, done_d;
  logic             in_rows, fire, last_row;

  always_comb begin
    in_rows   = (state_q == ST_ROWS);
    fire      = in_rows & pred_valid_i & rec_ready_i;
    last_row  = (row_q == (blk8_i ? LAST_LARGE : LAST_SMALL));
    load_job_o = (state_q == ST_IDLE) & start_i;
    en_mul_o  = (state_q == ST_MUL);
    en_shf_o  = (state_q == ST_SHF);
    en_res_o  = (state_q == ST_RES);

    state_d = state_q;
    row_d   = row_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_MUL;
        row_d   = '0;
      end
      ST_MUL:  state_d = ST_SHF;
      ST_SHF:  state_d = ST_RES;
      ST_RES:  state_d = ST_ROWS;
      ST_ROWS: if (fire) begin
        if (last_row) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          row_d = row_q + CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      done_q  <= done_d;
    end
  end

  assign pred_ready_o = in_rows & rec_ready_i;
  assign rec_valid_o  = in_rows & pred_valid_i;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;

endmodule

// File: rtl/dcr_dequant.sv
module dcr_dequant
  import dcr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_mul_i,
  input  logic                    en_shf_i,
  input  logic                    en_res_i,
  input  dcr_job_t                job_i,
  output logic signed [RES_W-1:0] res_o
);

  localparam int PROD_W = 2 * COEF_W;
  localparam int EXT_W  = PROD_W + 1;
  localparam int DQX_W  = COEF_W + 1;

  // Rounding arithmetic right shift followed by signed saturation to COEF_W bits
  function automatic logic [COEF_W-1:0] rshift_sat(input logic signed [EXT_W-1:0] v,
                                                    input int unsigned            sh);
    logic signed [EXT_W-1:0] bias;
    logic signed [EXT_W-1:0] r;
    logic                    fits;
    bias = EXT_W'(1) << (sh - 1);
    r    = (v + bias) >>> sh;
    fits = (&r[EXT_W-1:COEF_W-1]) | ~(|r[EXT_W-1:COEF_W-1]);
    if (fits)             rshift_sat = r[COEF_W-1:0];
    else if (r[EXT_W-1])  rshift_sat = {1'b1, {(COEF_W-1){1'b0}}};
    else                  rshift_sat = {1'b0, {(COEF_W-1){1'b1}}};
  endfunction

  logic        [PROD_W-1:0] scale_full;
  logic signed [PROD_W-1:0] scale_ext, dc_ext;
  logic signed [PROD_W-1:0] mult_d, mult_q;
  logic signed [PROD_W-1:0] shl;
  logic signed [EXT_W-1:0]  shl_ext;
  logic        [COEF_W-1:0] dq_small, dq_large;
  logic        [COEF_W-1:0] dq_d, dq_q;
  logic signed [DQX_W-1:0]  dq_ext, res_full;
  logic signed [RES_W-1:0]  res_d, res_q;

  // Stage 1: scale factor and signed product
  always_comb begin
    scale_full = PROD_W'(job_i.iscale) * PROD_W'(job_i.weight);
    scale_ext  = {{COEF_W{scale_full[COEF_W-1]}}, scale_full[COEF_W-1:0]};
    dc_ext     = {{COEF_W{job_i.dc[COEF_W-1]}}, job_i.dc};
    mult_d     = dc_ext * scale_ext;
  end

  // Stage 2: left shift within 32 bits, rounding right shift, saturation, bypass
  always_comb begin
    shl      = mult_q <<< job_i.qp;
    shl_ext  = {shl[PROD_W-1], shl};
    dq_small = rshift_sat(shl_ext, SH_SMALL);
    dq_large = rshift_sat(shl_ext, SH_LARGE);
    if (job_i.pre_dq & ~job_i.blk8) dq_d = job_i.alt;
    else if (job_i.blk8)            dq_d = dq_large;
    else                            dq_d = dq_small;
  end

  // Stage 3: residual rounding
  always_comb begin
    dq_ext   = {dq_q[COEF_W-1], dq_q};
    res_full = (dq_ext + DQX_W'(1 << (SH_RES - 1))) >>> SH_RES;
    res_d    = res_full[RES_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q <= '0;
      dq_q   <= '0;
      res_q  <= '0;
    end else begin
      if (en_mul_i) mult_q <= mult_d;
      if (en_shf_i) dq_q   <= dq_d;
      if (en_res_i) res_q  <= res_d;
    end
  end

  assign res_o = res_q;

endmodule

// File: rtl/dcr_row_adder.sv
module dcr_row_adder
  import dcr_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int MAX_N = 8
) (
  input  logic                    blk8_i,
  input  logic signed [RES_W-1:0] res_i,
  input  logic [PIX_W*MAX_N-1:0]  row_i,
  output logic [PIX_W*MAX_N-1:0]  row_o
);

  localparam int SUM_W = ((PIX_W + 1 > RES_W) ? PIX_W + 1 : RES_W) + 1;

  for (genvar k = 0; k < MAX_N; k++) begin : g_lane
    logic signed [SUM_W-1:0] pix_ext, res_ext, sum;
    logic        [PIX_W-1:0] clipped;
    logic                    active;

    always_comb begin
      pix_ext = {{(SUM_W-PIX_W){1'b0}}, row_i[k*PIX_W +: PIX_W]};
      res_ext = {{(SUM_W-RES_W){res_i[RES_W-1]}}, res_i};
      sum     = pix_ext + res_ext;
      if (sum[SUM_W-1])                 clipped = '0;
      else if (|sum[SUM_W-2:PIX_W])     clipped = '1;
      else                              clipped = sum[PIX_W-1:0];
      active  = blk8_i | (k < MAX_N / 2);
    end

    assign row_o[k*PIX_W +: PIX_W] = active ? clipped : '0;
  end

endmodule

// File: rtl/dcr_unit.sv
module dcr_unit
  import dcr_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int MAX_N = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   blk8_i,
  input  logic                   pre_dq_i,
  input  logic [15:0]            dc_coef_i,
  input  logic [15:0]            iscale_i,
  input  logic [15:0]            weight_i,
  input  logic [3:0]             qp_shift_i,
  input  logic [15:0]            dc_alt_i,
  output logic                   busy_o,
  input  logic                   pred_valid_i,
  output logic                   pred_ready_o,
  input  logic [PIX_W*MAX_N-1:0] pred_row_i,
  output logic                   rec_valid_o,
  input  logic                   rec_ready_i,
  output logic [PIX_W*MAX_N-1:0] rec_row_o,
  output logic                   done_o
);

  logic [1:0]              rst_sync_q;
  logic                    rst_int_n;
  dcr_job_t                job_q, job_d;
  logic                    load_job, en_mul, en_shf, en_res;
  logic signed [RES_W-1:0] residual;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    job_d.blk8   = blk8_i;
    job_d.pre_dq = pre_dq_i;
    job_d.dc     = dc_coef_i;
    job_d.iscale = iscale_i;
    job_d.weight = weight_i;
    job_d.qp     = qp_shift_i;
    job_d.alt    = dc_alt_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    job_q <= '0;
    else if (load_job) job_q <= job_d;
  end

  dcr_ctrl #(.MAX_N(MAX_N)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start_i      (start_i),
    .blk8_i       (job_q.blk8),
    .pred_valid_i (pred_valid_i),
    .rec_ready_i  (rec_ready_i),
    .load_job_o   (load_job),
    .en_mul_o     (en_mul),
    .en_shf_o     (en_shf),
    .en_res_o     (en_res),
    .pred_ready_o (pred_ready_o),
    .rec_valid_o  (rec_valid_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  dcr_dequant u_dequant (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en_mul_i (en_mul),
    .en_shf_i (en_shf),
    .en_res_i (en_res),
    .job_i    (job_q),
    .res_o    (residual)
  );

  dcr_row_adder #(.PIX_W(PIX_W), .MAX_N(MAX_N)) u_adder (
    .blk8_i (job_q.blk8),
    .res_i  (residual),
    .row_i  (pred_row_i),
    .row_o  (rec_row_o)
  );

endmodule

// File: rtl/dcr_unit_chk.sv
module dcr_unit_chk #(
  parameter int PIX_W = 8,
  parameter int MAX_N = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start_i,
  input logic                   blk8_i,
  input logic                   busy_o,
  input logic                   pred_valid_i,
  input logic                   pred_ready_o,
  input logic                   rec_valid_o,
  input logic [PIX_W*MAX_N-1:0] rec_row_o,
  input logic                   done_o
);

  localparam int HALF_W = PIX_W * MAX_N / 2;
  localparam int RC_W   = $clog2(MAX_N + 1);

  logic [1:0]      fill_q;
  logic [RC_W-1:0] rows_q;
  logic            blk8_q;

  // Checker-side bookkeeping: cycles since start (saturating) and rows moved
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      rows_q <= '0;
      blk8_q <= 1'b0;
    end else if (start_i && !busy_o) begin
      fill_q <= '0;
      rows_q <= '0;
      blk8_q <= blk8_i;
    end else begin
      if (busy_o && fill_q != 2'd3) fill_q <= fill_q + 2'd1;
      if (pred_valid_i && pred_ready_o) rows_q <= rows_q + RC_W'(1);
    end
  end

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!pred_ready_o && !rec_valid_o));

  assert_fill_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_ready_o || rec_valid_o) |-> (fill_q == 2'd3));

  assert_row_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (rows_q == (blk8_q ? RC_W'(MAX_N) : RC_W'(MAX_N / 2))));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && !blk8_q) |-> (rec_row_o[PIX_W*MAX_N-1:HALF_W] == '0));

endmodule

bind dcr_unit dcr_unit_chk #(.PIX_W(PIX_W), .MAX_N(MAX_N)) u_dcr_unit_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .blk8_i       (blk8_i),
  .busy_o       (busy_o),
  .pred_valid_i (pred_valid_i),
  .pred_ready_o (pred_ready_o),
  .rec_valid_o  (rec_valid_o),
  .rec_row_o    (rec_row_o),
  .done_o       (done_o)
);

// File: tb/test_dcr_unit.sv
module test_dcr_unit;

  localparam int PIX_W = 8;
  localparam int MAX_N = 8;
  localparam int RW    = PIX_W * MAX_N;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i, blk8_i, pre_dq_i;
  logic [15:0]   dc_coef_i, iscale_i, weight_i, dc_alt_i;
  logic [3:0]    qp_shift_i;
  logic          busy_o, pred_valid_i, pred_ready_o, rec_valid_o, rec_ready_i, done_o;
  logic [RW-1:0] pred_row_i, rec_row_o;

  int n_chk = 0;
  int n_bad = 0;
  int seed_dummy;

  always #5 clk = ~clk;

  dcr_unit #(.PIX_W(PIX_W), .MAX_N(MAX_N)) i_dcr_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk8_i(blk8_i), .pre_dq_i(pre_dq_i),
    .dc_coef_i(dc_coef_i), .iscale_i(iscale_i), .weight_i(weight_i),
    .qp_shift_i(qp_shift_i), .dc_alt_i(dc_alt_i), .busy_o(busy_o),
    .pred_valid_i(pred_valid_i), .pred_ready_o(pred_ready_o), .pred_row_i(pred_row_i),
    .rec_valid_o(rec_valid_o), .rec_ready_i(rec_ready_i), .rec_row_o(rec_row_o),
    .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Residual from the requirements R1..R6
  function automatic longint exp_res(input bit b8, input bit byp,
                                     input logic [15:0] dc, input logic [15:0] isc,
                                     input logic [15:0] wt, input int qp,
                                     input logic [15:0] alt);
    longint m, sc, p, s, r, dq;
    int sh;
    m  = (longint'(isc) * longint'(wt)) & 64'hFFFF;
    sc = (m >= 32768) ? m - 65536 : m;
    p  = longint'($signed(dc)) * sc;
    s  = (p << qp) & 64'hFFFF_FFFF;
    if (s >= 64'h8000_0000) s = s - 64'h1_0000_0000;
    sh = b8 ? 6 : 4;
    r  = (s + (longint'(1) << (sh - 1))) >>> sh;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    dq = (!b8 && byp) ? longint'($signed(alt)) : r;
    return (dq + 32) >>> 6;
  endfunction

  function automatic logic [RW-1:0] exp_row(input bit b8, input longint res,
                                            input logic [RW-1:0] pred);
    logic [RW-1:0] o;
    o = '0;
    for (int k = 0; k < MAX_N; k++) begin
      longint v;
      v = longint'(pred[k*PIX_W +: PIX_W]) + res;
      if (v < 0)   v = 0;
      if (v > 255) v = 255;
      if (b8 || k < MAX_N / 2) o[k*PIX_W +: PIX_W] = PIX_W'(v);
    end
    return o;
  endfunction

  function automatic logic [RW-1:0] rand_row();
    logic [RW-1:0] r;
    for (int k = 0; k < MAX_N; k++) begin
      int sel;
      sel = $urandom_range(0, 5);
      r[k*PIX_W +: PIX_W] = (sel == 0) ? 8'd0 : (sel == 1) ? 8'd255 : PIX_W'($urandom);
    end
    return r;
  endfunction

  task automatic run_block(input bit b8, input bit byp, input logic [15:0] dc,
                           input logic [15:0] isc, input logic [15:0] wt, input int qp,
                           input logic [15:0] alt, input bit poke, input string tag);
    longint        res;
    int            rows, got;
    logic [RW-1:0] row, er;
    res  = exp_res(b8, byp, dc, isc, wt, qp, alt);
    rows = b8 ? MAX_N : MAX_N / 2;
    @(negedge clk);
    start_i = 1'b1; blk8_i = b8; pre_dq_i = byp; dc_coef_i = dc;
    iscale_i = isc; weight_i = wt; qp_shift_i = 4'(qp); dc_alt_i = alt;
    pred_valid_i = 1'b0; rec_ready_i = 1'b0;
    // Three fill cycles; inputs scrambled to show they were latched (R8)
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      start_i      = (poke && c == 0);
      blk8_i       = 1'($urandom); pre_dq_i = 1'($urandom);
      dc_coef_i    = 16'($urandom); iscale_i = 16'($urandom);
      weight_i     = 16'($urandom); qp_shift_i = 4'($urandom); dc_alt_i = 16'($urandom);
      pred_valid_i = 1'b1; rec_ready_i = 1'b1; pred_row_i = rand_row();
      #1;
      check(!pred_ready_o && !rec_valid_o, "R9", "handshake during fill",
            RW'({pred_ready_o, rec_valid_o}), '0);
      check(busy_o, "R8", "busy after start", RW'(busy_o), RW'(1));
    end
    start_i = 1'b0;
    got = 0;
    while (got < rows) begin
      @(negedge clk);
      pred_valid_i = ($urandom_range(0, 3) != 0);
      rec_ready_i  = ($urandom_range(0, 3) != 0);
      row          = rand_row();
      pred_row_i   = row;
      #1;
      check(rec_valid_o == pred_valid_i && pred_ready_o == rec_ready_i, "R10",
            "valid/ready follow", RW'({rec_valid_o, pred_ready_o}),
            RW'({pred_valid_i, rec_ready_i}));
      if (pred_valid_i && rec_ready_i) begin
        er = exp_row(b8, res, row);
        check(rec_row_o === er, {tag, " R5 R7 R8"}, $sformatf("row %0d", got),
              rec_row_o, er);
        got++;
      end
    end
    @(negedge clk);
    pred_valid_i = 1'b0; rec_ready_i = 1'b0;
    #1;
    check(done_o && !busy_o, "R11", "done pulse after last row",
          RW'({done_o, busy_o}), RW'(2'b10));
    @(negedge clk);
    #1;
    check(!done_o, "R11", "done is one cycle", RW'(done_o), '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'h5eed_2d0c);
    rst_n = 1'b0; start_i = 1'b0; blk8_i = 1'b0; pre_dq_i = 1'b0;
    dc_coef_i = '0; iscale_i = '0; weight_i = '0; qp_shift_i = '0; dc_alt_i = '0;
    pred_valid_i = 1'b1; rec_ready_i = 1'b1; pred_row_i = '1;
    repeat (3) @(negedge clk);
    #1;
    check(!busy_o && !done_o && !pred_ready_o && !rec_valid_o, "R10", "reset state",
          RW'({busy_o, done_o, pred_ready_o, rec_valid_o}), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(!pred_ready_o && !rec_valid_o, "R10", "idle quiet",
          RW'({pred_ready_o, rec_valid_o}), '0);
    pred_valid_i = 1'b0; rec_ready_i = 1'b0;

    // Directed corners
    run_block(0, 0, 16'd100,   16'd10,  16'd16,  2,  16'd0,     0, "R3");
    run_block(1, 0, 16'd100,   16'd10,  16'd16,  2,  16'd0,     0, "R4");
    run_block(0, 0, 16'd37,    16'd256, 16'd255, 0,  16'd0,     0, "R1");
    run_block(1, 0, 16'hFFF3,  16'd256, 16'd255, 1,  16'd0,     0, "R1");
    run_block(0, 0, 16'd3,     16'd1,   16'd1,   15, 16'd0,     0, "R2");
    run_block(1, 0, 16'h7FFF,  16'd16,  16'd16,  15, 16'd0,     0, "R2");
    run_block(0, 0, 16'h7FFF,  16'd16,  16'd16,  4,  16'd0,     0, "R3");
    run_block(0, 0, 16'h8000,  16'd16,  16'd16,  4,  16'd0,     0, "R3");
    run_block(1, 0, 16'h7FFF,  16'd64,  16'd16,  6,  16'd0,     0, "R4");
    run_block(1, 0, 16'h8000,  16'd64,  16'd16,  6,  16'd0,     0, "R4");
    run_block(0, 1, 16'd500,   16'd20,  16'd16,  3,  16'h8000,  0, "R6");
    run_block(0, 1, 16'd0,     16'd20,  16'd16,  3,  16'h7FFF,  0, "R6");
    run_block(0, 1, 16'h1234,  16'd20,  16'd16,  3,  16'd31,    0, "R6");
    run_block(1, 1, 16'd0,     16'd20,  16'd16,  3,  16'h7FFF,  0, "R6");
    run_block(1, 0, 16'd50,    16'd11,  16'd16,  3,  16'd0,     1, "R8");
    run_block(0, 0, 16'hFF00,  16'd13,  16'd16,  2,  16'd0,     1, "R8");

    // Constrained random blocks: moderate scales, any shift and sign
    for (int i = 0; i < 40; i++) begin
      run_block(1'($urandom), ($urandom_range(0, 3) == 0), 16'($urandom),
                16'($urandom_range(1, 40)), 16'($urandom_range(1, 32)),
                $urandom_range(0, 15), 16'($urandom), ($urandom_range(0, 4) == 0),
                "R1 R2 R3 R4 R6");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule